// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is a memory-mapped SPI master reached through eight byte-wide registers on a 3-bit address. When software writes a byte to the data port, the byte joins a small transmit queue. A shift engine then takes it and runs one full-duplex 8-bit exchange, most significant bit first. The byte clocked in during that exchange goes into a receive queue, and software pops it by reading the same data port. Every byte sent produces exactly one byte received.

Clock polarity and phase are programmable, so all four SPI modes are available. The SCK rate comes from a 4-bit code split between two registers. Four chip-select lines are under direct software control: each line has one bit that hands it to software and one bit that sets its level.

A master enable bit gates the shift engine. Status flags report queue occupancy, engine activity and a sticky flag that records a write dropped because the transmit queue was full.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the registers read: control (offset 0) 0x51, status (offset 1) 0x05, rate-extension (offset 3) 0x00, flash-parameter (offset 4) 0x40, select (offset 5) 0x00, timing (offset 6) 0x01. All chip selects are high and SCK is low.
- R2: The control, rate-extension, flash-parameter, select and timing registers read back the last byte written to them.
- R3: Writing offset 2 starts an 8-bit exchange. MOSI carries the written byte MSB first, and the byte shifted in on MISO, MSB first, is later returned by a read of offset 2.
- R4: Control bit 3 is CPOL and bit 2 is CPHA. SCK rests at the CPOL level while idle. MISO is sampled on the first SCK edge of each bit when CPHA=0 and on the second when CPHA=1. MOSI is stable on the edge where the far end samples.
- R5: The rate code is {ext[1:0], ctrl[1:0]}. The SCK period in clock cycles is 2, 4, 16, 32 and 8 for codes 0, 1, 2, 3 and 4. For code k from 5 to 11 it is 2^(k+1), and codes 12 to 15 give 4096.
- R6: The transmit queue holds 4 bytes. A data write while it is full is dropped and sets status bit 6. Writing the status register with bit 6 set clears that flag.
- R7: Status bit 0 is receive-queue empty, bit 1 is receive-queue full, bit 2 is transmit-queue empty, bit 3 is transmit-queue full, and bit 7 is engine busy.
- R8: A data-port read while the receive queue is empty returns the most recently popped byte and changes nothing.
- R9: Control bit 6 enables the engine. While it is clear, no new exchange starts, queued bytes wait, and SCK follows CPOL. Setting it lets the queued bytes go out.
- R10: For select line n (0..3), select bit n gives the line to software and bit n+4 is its level. A line whose bit n is clear is driven high.
- R11: While the receive queue holds 4 unread bytes, no exchange starts. No received byte is ever lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; pops the receive queue at offset 2 |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |

## Verification
The checks on SCK resting level take it for granted that software changes polarity, phase and rate only while the engine is idle. They also assume that each strobe lasts exactly one cycle, and that MISO settles within half an SCK period after the edge on which the far end shifts. The stimulus respects all three. It writes the control register only after polling status until the busy and transmit-empty flags show an idle engine, and it pauses a few cycles after each mode change before arming its slave model. Its strobes are driven on falling clock edges, and the slave model updates MISO just after each of its sampling edges, a full half period before the master samples again.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
   localparam int HALF_W = 12;

   // Half SCK period, in clk cycles, for a 4-bit rate code.
   function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
      int e;
      case (code)
         4'd0:    e = 1;
         4'd1:    e = 2;
         4'd2:    e = 4;
         4'd3:    e = 5;
         4'd4:    e = 3;
         default: e = (code > 4'd11) ? 12 : int'(code) + 1;
      endcase
      return HALF_W'(1) << (e - 1);
   endfunction
endpackage

// File: rtl/spi_bm_fifo.sv
`timescale 1ns/1ps
module spi_bm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("spi_bm_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign dout  = mem[rp[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wp[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) wp <= wp + 1'b1;
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end
endmodule

// File: rtl/spi_bm_shift.sv
`timescale 1ns/1ps
module spi_bm_shift
   import spi_bm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [HALF_W-1:0] half,
   input  logic              start,
   input  logic [W-1:0]      tx_byte,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              busy,
   output logic              done,
   output logic [W-1:0]      rx_byte
);
   localparam int EW = $clog2(2 * W);
   localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

   logic [HALF_W-1:0] cnt;
   logic [EW-1:0]     edge_q;
   logic [W-1:0]      tx_sr, rx_sr;
   logic              sck_q, busy_q, done_q;

   assign sck     = sck_q;
   assign mosi    = tx_sr[W-1];
   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         edge_q <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
         sck_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            sck_q <= cpol;
            if (start) begin
               busy_q <= 1'b1;
               tx_sr  <= tx_byte;
               cnt    <= '0;
               edge_q <= '0;
            end
         end else if (cnt == half - HALF_W'(1)) begin
            cnt    <= '0;
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            // even edges sample for CPHA=0, odd edges for CPHA=1
            if (edge_q[0] == cpha)
               rx_sr <= {rx_sr[W-2:0], miso};
            else if (edge_q != '0)
               tx_sr <= {tx_sr[W-2:0], 1'b0};
            if (edge_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
   import spi_bm_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter int NCS        = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   input  logic             reg_rd,
   output logic [7:0]       reg_rdata,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic [NCS-1:0]   cs_n
);
   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_STAT = 3'd1;
   localparam logic [2:0] A_DATA = 3'd2;
   localparam logic [2:0] A_EXT  = 3'd3;
   localparam logic [2:0] A_PRM  = 3'd4;
   localparam logic [2:0] A_CSEL = 3'd5;
   localparam logic [2:0] A_TIM  = 3'd6;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("spi_byte_master: only 8-bit words are supported");
      end
      if (NCS < 1 || NCS > 4) begin : g_bad_ncs
         $error("spi_byte_master: NCS must be 1 to 4");
      end
   endgenerate

   logic [7:0] ctrl_q, ext_q, prm_q, csel_q, tim_q;
   logic       wcol_q;
   logic [7:0] last_rd_q;

   logic              en, cpol, cpha;
   logic [HALF_W-1:0] half;
   logic              data_wr, data_rd;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [7:0]        tx_head, rx_head, rx_byte;
   logic              busy, done, start;

   assign en   = ctrl_q[6];
   assign cpol = ctrl_q[3];
   assign cpha = ctrl_q[2];
   assign half = half_period({ext_q[1:0], ctrl_q[1:0]});

   assign data_wr = reg_wr && (reg_addr == A_DATA);
   assign data_rd = reg_rd && (reg_addr == A_DATA) && !rx_empty;
   assign start   = en && !busy && !done && !tx_empty && !rx_full;

   spi_bm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(data_wr), .din(reg_wdata),
      .pop(start), .dout(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   spi_bm_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(done), .din(rx_byte),
      .pop(data_rd), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   spi_bm_shift #(.W(8)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cpol(cpol), .cpha(cpha), .half(half),
      .start(start), .tx_byte(tx_head), .miso(miso),
      .sck(sck), .mosi(mosi), .busy(busy), .done(done),
      .rx_byte(rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= 8'h51;
         ext_q     <= 8'h00;
         prm_q     <= 8'h40;
         csel_q    <= 8'h00;
         tim_q     <= 8'h01;
         wcol_q    <= 1'b0;
         last_rd_q <= 8'h00;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               A_CTRL:  ctrl_q <= reg_wdata;
               A_EXT:   ext_q  <= reg_wdata;
               A_PRM:   prm_q  <= reg_wdata;
               A_CSEL:  csel_q <= reg_wdata;
               A_TIM:   tim_q  <= reg_wdata;
               default: ;
            endcase
         end
         if (data_wr && tx_full)
            wcol_q <= 1'b1;
         else if (reg_wr && reg_addr == A_STAT && reg_wdata[6])
            wcol_q <= 1'b0;
         if (data_rd) last_rd_q <= rx_head;
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = ctrl_q;
         A_STAT:  reg_rdata = {busy, wcol_q, 2'b00, tx_full, tx_empty, rx_full, rx_empty};
         A_DATA:  reg_rdata = rx_empty ? last_rd_q : rx_head;
         A_EXT:   reg_rdata = ext_q;
         A_PRM:   reg_rdata = prm_q;
         A_CSEL:  reg_rdata = csel_q;
         A_TIM:   reg_rdata = tim_q;
         default: reg_rdata = 8'h00;
      endcase
   end

   generate
      for (genvar i = 0; i < NCS; i++) begin : g_cs
         assign cs_n[i] = csel_q[i] ? csel_q[i+4] : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/spi_bm_checker.sv
`timescale 1ns/1ps
module spi_bm_checker #(
   parameter int NCS = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           en,
   input logic           cpol,
   input logic           busy,
   input logic           sck,
   input logic           data_wr,
   input logic           tx_full,
   input logic           wcol,
   input logic           rx_push,
   input logic           rx_full,
   input logic [7:0]     csel,
   input logic [NCS-1:0] cs_n
);
   AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol)); // R4

   AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !busy) |=> !busy); // R9

   AST_FULL_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_full) |=> wcol); // R6

   AST_RX_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> !rx_full); // R11

   AST_CS_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(csel) |-> $stable(cs_n)); // R10
endmodule

bind spi_byte_master spi_bm_checker #(.NCS(NCS)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .busy(busy),
   .sck(sck), .data_wr(data_wr), .tx_full(tx_full), .wcol(wcol_q),
   .rx_push(done), .rx_full(rx_full), .csel(csel_q), .cs_n(cs_n)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       sck, mosi, miso;
   logic [3:0] cs_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   spi_byte_master dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // Slave model: samples MOSI and advances MISO on its sampling edge.
   logic [31:0] s_sh = '0;
   logic [7:0]  s_rx = '0;
   logic        samp_lvl = 1'b1;
   assign miso = s_sh[31];
   always @(sck) begin
      if (sck === samp_lvl) begin
         s_rx = {s_rx[6:0], mosi};
         s_sh = {s_sh[30:0], 1'b1};
      end
   end

   // {mode[1:0], tx byte, slave byte}
   localparam int NV = 6;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 8'hA5, 8'h3C}, {2'd1, 8'h5A, 8'hC3}, {2'd2, 8'h81, 8'h7E},
      {2'd3, 8'h0F, 8'hF0}, {2'd0, 8'hFF, 8'h00}, {2'd3, 8'h01, 8'h80}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      for (int k = 0; k < 20000; k++) begin
         rd(3'd1, s);
         if (!s[7] && s[2]) return;
      end
      chk("idle-timeout", 32'd1, 32'd0);
   endtask

   task automatic set_mode(input logic [1:0] m, input logic [1:0] lo);
      wr(3'd0, 8'h50 | {4'b0, m, lo});
      repeat (3) @(negedge clk);
      samp_lvl = (m[1] == m[0]);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int t1, t2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, d); chk("R1 ctrl", d, 8'h51);
      rd(3'd1, d); chk("R1 status", d, 8'h05);
      rd(3'd3, d); chk("R1 ext", d, 8'h00);
      rd(3'd4, d); chk("R1 param", d, 8'h40);
      rd(3'd5, d); chk("R1 select", d, 8'h00);
      rd(3'd6, d); chk("R1 timing", d, 8'h01);
      chk("R1 cs_n", cs_n, 4'hF);
      chk("R1 sck", sck, 1'b0);

      // R3 / R4 vector walk over all modes
      for (int i = 0; i < NV; i++) begin
         set_mode(VEC[i][17:16], 2'd1);
         chk("R4 idle level", sck, VEC[i][17]);
         s_sh = {VEC[i][7:0], 24'h0};
         s_rx = '0;
         wr(3'd2, VEC[i][15:8]);
         wait_idle();
         chk("R4 rest after", sck, VEC[i][17]);
         chk("R3 slave saw tx", s_rx, VEC[i][15:8]);
         rd(3'd2, d); chk("R3 rx byte", d, VEC[i][7:0]);
      end

      // R2 readback
      wr(3'd4, 8'hA5); rd(3'd4, d); chk("R2 param", d, 8'hA5);
      wr(3'd6, 8'h3C); rd(3'd6, d); chk("R2 timing", d, 8'h3C);
      wr(3'd3, 8'hF0); rd(3'd3, d); chk("R2 ext", d, 8'hF0);
      wr(3'd3, 8'h00);

      // R5 rate codes
      for (int c = 0; c < 6; c++) begin
         int exp_p;
         case (c)
            0: exp_p = 2; 1: exp_p = 4; 2: exp_p = 16;
            3: exp_p = 32; 4: exp_p = 8; default: exp_p = 64;
         endcase
         wr(3'd3, {6'b0, 2'(c >> 2)});
         set_mode(2'd0, 2'(c));
         s_sh = '0;
         wr(3'd2, 8'h55);
         @(posedge sck); t1 = int'($time);
         @(posedge sck); t2 = int'($time);
         chk("R5 sck period", (t2 - t1) / 8, exp_p);
         wait_idle();
         rd(3'd2, d);
      end
      wr(3'd3, 8'h00);
      set_mode(2'd0, 2'd1);

      // R9 enable gate
      wr(3'd0, 8'h11);
      wr(3'd2, 8'h3C);
      repeat (40) @(negedge clk);
      rd(3'd1, d); chk("R9 held status", d, 8'h01);
      wr(3'd0, 8'h19);
      repeat (3) @(negedge clk);
      chk("R9 sck follows cpol", sck, 1'b1);
      wr(3'd0, 8'h11);
      repeat (3) @(negedge clk);
      samp_lvl = 1'b1;
      s_sh = {8'h96, 24'h0};
      wr(3'd0, 8'h51);
      wait_idle();
      rd(3'd2, d); chk("R9 released byte", d, 8'h96);

      // R6 / R7 full transmit queue
      wr(3'd0, 8'h11);
      for (int k = 0; k < 4; k++) wr(3'd2, 8'(8'h10 + k));
      rd(3'd1, d); chk("R7 tx full", d, 8'h09);
      wr(3'd2, 8'hEE);
      rd(3'd1, d); chk("R6 collision set", d, 8'h49);
      wr(3'd1, 8'h40);
      rd(3'd1, d); chk("R6 collision clear", d, 8'h09);

      // R11 receive queue full stalls the engine
      s_sh = 32'hC1D2E3F4;
      wr(3'd0, 8'h51);
      wait_idle();
      rd(3'd1, d); chk("R7 rx full", d, 8'h06);
      wr(3'd2, 8'h77);
      repeat (50) @(negedge clk);
      rd(3'd1, d); chk("R11 stalled", d, 8'h02);
      rd(3'd2, d); chk("R11 rx0", d, 8'hC1);
      rd(3'd2, d); chk("R11 rx1", d, 8'hD2);
      rd(3'd2, d); chk("R11 rx2", d, 8'hE3);
      rd(3'd2, d); chk("R11 rx3", d, 8'hF4);
      wait_idle();
      rd(3'd2, d); chk("R11 fifth byte", d, 8'hFF);

      // R8 empty read
      rd(3'd2, d); chk("R8 empty read", d, 8'hFF);
      rd(3'd1, d); chk("R8 status", d, 8'h05);

      // R10 chip selects
      wr(3'd5, 8'h01); chk("R10 cs0 low", cs_n, 4'b1110);
      wr(3'd5, 8'h13); chk("R10 mixed", cs_n, 4'b1101);
      wr(3'd5, 8'hF0); chk("R10 no enables", cs_n, 4'hF);
      wr(3'd5, 8'h0F); chk("R10 all low", cs_n, 4'h0);
      rd(3'd5, d); chk("R2 select", d, 8'h0F);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule